// File: doc/BRIEF.md
# Transmit Retry Abort Controller

This block manages the collision attempts for the frame at the head of a transmit FIFO and recovers the FIFO when the frame has to be given up. It owns the FIFO write, read and frame-start pointers, and it marks which FIFO slot holds the last byte of each frame. Each attempt that ends in a collision rewinds the read pointer to the start of the frame. The sixteenth failed attempt ends the frame. At that point the block drops its DMA request and posts a retry error in the status byte. It also raises an interrupt, which can be masked.

After an abort the block stalls. No attempt may start and no FIFO write is accepted until the host reads the status byte. That read clears the error and decrements the host-visible frame counter. It also repairs the FIFO in one of two ways. If the aborted frame's last byte is already in the FIFO, the read pointer skips past that frame and the write pointer is left alone. If the frame has no end mark yet, the whole transmit path is cleared and the request watermark is reloaded from its configuration input.

While an attempt has sent fewer than a slot's worth of bytes, space is counted from the frame start, not from the read pointer. This keeps a retry able to resend from the first byte.

Top module: `tx_retry_abort`

## Requirements
- R1: Each attempt that ends with `att_coll` increments the attempt count, visible in status bits 4:0 (`reg_addr`=0). `att_ok` clears the count. A status read (`reg_rd` with `reg_addr`=0) also clears it when no attempt is in progress.
- R2: When the collision that completes attempt number MAX_ATTEMPTS (16) arrives, the next cycle shows the following: status bit 7 (retry error) set, `irq` high if unmasked, `tx_dreq` low, `tx_go` low, and a status value of 0x90.
- R3: A collision on an earlier attempt returns `rd_addr` to the first byte of the frame, and `tx_go` stays high so the frame can be retried.
- R4: `irq` is high exactly when the pending transmit interrupt is set and `int_mask` is low.
- R5: A status read clears the retry error and the interrupt. It decrements the frame counter (`reg_addr`=1), which stays at zero if already zero.
- R6: From the abort until the status read, `tx_go` is low, `att_start` has no effect and FIFO writes are ignored, even with complete frames waiting.
- R7: A status read after an abort, with the frame's end mark present, moves `rd_addr` to the slot after that mark and leaves `wr_addr` unchanged.
- R8: A status read after an abort, with no end mark for the frame, sets both pointers to 0, empties the FIFO and reloads the request watermark from `cfg_wmark`.
- R9: Until SLOT_BYTES bytes of the current attempt have been read, free space is measured from the frame start. `tx_dreq` is high only when not stalled and free space is at least the watermark. Writes to a full FIFO are ignored.
- R10: A write with `wr_eof` increments the frame counter.
- R11: After reset both pointers are 0, status and counter read 0, `tx_go` and `irq` are low, `tx_dreq` is high, and the watermark is WM_INIT (16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push one byte into the FIFO |
| wr_eof | input | 1 | Pushed byte is the last of its frame |
| rd_en | input | 1 | Serializer fetches one byte of the current attempt |
| att_start | input | 1 | MAC begins an attempt |
| att_coll | input | 1 | Current attempt ended by collision |
| att_ok | input | 1 | Current attempt completed successfully |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects frame counter |
| int_mask | input | 1 | Masks the interrupt output |
| cfg_wmark | input | AW+1 | Watermark loaded on a path reset |
| tx_dreq | output | 1 | DMA write request |
| tx_go | output | 1 | An attempt may start |
| irq | output | 1 | Interrupt |
| rd_addr | output | AW | FIFO read address |
| wr_addr | output | AW | FIFO write address |
| reg_rdata | output | 8 | Register read data |

## Verification
Register data, `tx_go`, `tx_dreq` and `irq` change in the same cycle as a register selection or mask change. Every pointer, counter and flag effect of a write, fetch, attempt outcome or status read shows up one clock after the edge that captures it. The bench drives inputs on the falling edge and compares every output half a nanosecond later with a behavioural model. The model applies its update after that comparison, so each expected value belongs to the same cycle the design is in. Directed checks for the abort, the skip, the path reset and the slot protection sample in the idle cycle that follows the stimulus.

// File: rtl/tx_retry_abort.sv
module tx_retry_abort #(
  parameter int AW           = 7,
  parameter int SLOT_BYTES   = 64,
  parameter int MAX_ATTEMPTS = 16,
  parameter int CNT_W        = 5,
  parameter int FC_W         = 4,
  parameter int WM_INIT      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_eof,
  input  logic          rd_en,
  input  logic          att_start,
  input  logic          att_coll,
  input  logic          att_ok,
  input  logic          reg_rd,
  input  logic          reg_addr,
  input  logic          int_mask,
  input  logic [AW:0]   cfg_wmark,
  output logic          tx_dreq,
  output logic          tx_go,
  output logic          irq,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    reg_rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int SW    = $clog2(SLOT_BYTES + 1);

  logic [PW-1:0]    wr_p, rd_p, st_p, prot, used, rd_inc, skip_p;
  logic [PW:0]      free;
  logic [DEPTH-1:0] eof_m;
  logic [FC_W-1:0]  fc, rdy;
  logic [CNT_W-1:0] att;
  logic [SW-1:0]    sent;
  logic [PW-1:0]    wm;
  logic             busy, stall, rtry, xint;
  logic             full, wr_ok, start_ok, rd_ok, coll_ok, ok_ok, last, st_rd, path_rst, skip;

  assign prot     = (sent >= SW'(SLOT_BYTES)) ? rd_p : st_p;
  assign used     = wr_p - prot;
  assign free     = (PW+1)'(DEPTH) - {1'b0, used};
  assign full     = used == PW'(DEPTH);
  assign wr_ok    = wr_en && !stall && !full;
  assign tx_go    = !stall && !busy && (wr_p != st_p);
  assign tx_dreq  = !stall && !full && (free >= {1'b0, wm});
  assign start_ok = att_start && tx_go;
  assign rd_ok    = rd_en && busy && (rd_p != wr_p);
  assign coll_ok  = att_coll && busy;
  assign ok_ok    = att_ok && busy && !att_coll;
  assign last     = coll_ok && (att == CNT_W'(MAX_ATTEMPTS - 1));
  assign st_rd    = reg_rd && !reg_addr;
  assign path_rst = st_rd && stall && (rdy == '0);
  assign skip     = st_rd && stall && (rdy != '0);
  assign rd_inc   = rd_p + PW'(rd_ok);
  assign irq      = xint && !int_mask;
  assign rd_addr  = rd_p[AW-1:0];
  assign wr_addr  = wr_p[AW-1:0];
  assign reg_rdata = reg_addr ? 8'(fc) : {rtry, 7'(att)};

  always_comb begin
    skip_p = st_p;
    for (int k = DEPTH - 1; k >= 0; k--)
      if (eof_m[AW'(st_p[AW-1:0] + AW'(k))]) skip_p = st_p + PW'(k) + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p <= '0; rd_p <= '0; st_p <= '0; eof_m <= '0;
      fc <= '0; rdy <= '0; att <= '0; sent <= '0; wm <= PW'(WM_INIT);
      busy <= 1'b0; stall <= 1'b0; rtry <= 1'b0; xint <= 1'b0;
    end else begin
      fc <= fc + FC_W'(wr_ok && wr_eof) - FC_W'(st_rd && (fc != '0));
      if (st_rd) begin
        rtry <= 1'b0;
        xint <= 1'b0;
        if (!busy) att <= '0;
      end
      if (path_rst) begin
        wr_p <= '0; rd_p <= '0; st_p <= '0; eof_m <= '0;
        rdy <= '0; sent <= '0; wm <= cfg_wmark; stall <= 1'b0;
      end else begin
        if (wr_ok) begin
          eof_m[wr_p[AW-1:0]] <= wr_eof;
          wr_p <= wr_p + PW'(1);
        end
        rdy <= rdy + FC_W'(wr_ok && wr_eof) - FC_W'(ok_ok || skip);
        if (skip) begin
          rd_p <= skip_p; st_p <= skip_p; stall <= 1'b0; sent <= '0;
        end
        if (start_ok) begin
          busy <= 1'b1; sent <= '0;
        end
        if (rd_ok) begin
          rd_p <= rd_inc;
          if (sent != SW'(SLOT_BYTES)) sent <= sent + SW'(1);
        end
        if (coll_ok) begin
          busy <= 1'b0; sent <= '0; rd_p <= st_p; att <= att + CNT_W'(1);
          if (last) begin
            stall <= 1'b1; rtry <= 1'b1; xint <= 1'b1;
          end
        end
        if (ok_ok) begin
          busy <= 1'b0; att <= '0; st_p <= rd_inc; sent <= '0;
        end
      end
    end
  end

  assert_att_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    att <= CNT_W'(MAX_ATTEMPTS));
  assert_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> stall && rtry && xint && !tx_dreq);
  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !st_rd |=> $stable(rd_p) && $stable(wr_p));
  assert_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    skip |=> $stable(wr_p) && !stall && (rd_p == st_p));
  assert_path_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    path_rst |=> (wr_p == '0) && (rd_p == '0) && (wm == $past(cfg_wmark)));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH));
endmodule

// File: tb/tx_retry_abort_tb_top.sv
`timescale 1ns/100ps
module tx_retry_abort_tb_top;
  localparam int AW = 7;
  localparam int DEPTH = 128;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_eof = 0, rd_en = 0, att_start = 0, att_coll = 0, att_ok = 0;
  logic reg_rd = 0, reg_addr = 0, int_mask = 0;
  logic [AW:0] cfg_wmark = 8'd16;
  logic tx_dreq, tx_go, irq;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0] reg_rdata;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  tx_retry_abort dut_i (.clk, .rst_n, .wr_en, .wr_eof, .rd_en, .att_start, .att_coll,
    .att_ok, .reg_rd, .reg_addr, .int_mask, .cfg_wmark, .tx_dreq, .tx_go, .irq,
    .rd_addr, .wr_addr, .reg_rdata);

  always #2.5 clk = ~clk;

  // behavioural reference
  int m_wr, m_rd, m_st, m_fc, m_att, m_sent, m_wm;
  bit m_busy, m_stall, m_rtry, m_xint;
  int eofq[$];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    m_wr = 0; m_rd = 0; m_st = 0; m_fc = 0; m_att = 0; m_sent = 0; m_wm = 16;
    m_busy = 0; m_stall = 0; m_rtry = 0; m_xint = 0; eofq.delete();
  endtask

  always @(negedge clk) begin
    #0.5;
    if (!rst_n) m_reset();
    begin
      int prot, used, ns;
      bit full, wr_ok, go, start_ok, rd_ok, coll_ok, ok_ok, st_rd;
      prot = (m_sent >= 64) ? m_rd : m_st;
      used = m_wr - prot;
      full = used == DEPTH;
      go = !m_stall && !m_busy && (m_wr != m_st);
      chk("R6 tx_go", tx_go, go);
      chk("R9 tx_dreq", tx_dreq, !m_stall && !full && (DEPTH - used) >= m_wm);
      chk("R4 irq", irq, m_xint && !int_mask);
      chk("R7 rd_addr", rd_addr, m_rd % DEPTH);
      chk("R8 wr_addr", wr_addr, m_wr % DEPTH);
      chk("R5 reg_rdata", reg_rdata, reg_addr ? m_fc : (m_rtry * 128 + m_att));
      if (rst_n) begin
        wr_ok = wr_en && !m_stall && !full;
        start_ok = att_start && go;
        rd_ok = rd_en && m_busy && (m_rd != m_wr);
        coll_ok = att_coll && m_busy;
        ok_ok = att_ok && m_busy && !att_coll;
        st_rd = reg_rd && !reg_addr;
        if (wr_ok && wr_eof) m_fc++;
        if (st_rd && m_fc > 0) m_fc--;
        if (st_rd) begin
          m_rtry = 0; m_xint = 0;
          if (!m_busy) m_att = 0;
        end
        if (st_rd && m_stall) begin
          m_stall = 0; m_sent = 0;
          if (eofq.size() == 0) begin
            m_wr = 0; m_rd = 0; m_st = 0; m_wm = cfg_wmark;
          end else begin
            ns = eofq.pop_front() + 1;
            m_rd = ns; m_st = ns;
          end
        end else begin
          if (wr_ok) begin
            if (wr_eof) eofq.push_back(m_wr);
            m_wr++;
          end
          if (start_ok) begin m_busy = 1; m_sent = 0; end
          if (rd_ok) begin
            m_rd++;
            if (m_sent < 64) m_sent++;
          end
          if (coll_ok) begin
            m_busy = 0; m_sent = 0; m_rd = m_st; m_att++;
            if (m_att == 16) begin m_stall = 1; m_rtry = 1; m_xint = 1; end
          end
          if (ok_ok) begin
            m_busy = 0; m_att = 0; m_st = m_rd; m_sent = 0;
            void'(eofq.pop_front());
          end
        end
      end
    end
  end

  task automatic step(bit w = 0, bit e = 0, bit r = 0, bit s = 0, bit c = 0, bit o = 0,
                      bit rr = 0, bit a = 0);
    @(negedge clk);
    wr_en = w; wr_eof = e; rd_en = r; att_start = s; att_coll = c; att_ok = o;
    reg_rd = rr; reg_addr = a;
  endtask

  task automatic look(bit a);
    step(.a(a));
    #1;
  endtask

  task automatic write_frame(int n, bit with_eof);
    for (int i = 0; i < n; i++) step(.w(1), .e(with_eof && i == n - 1));
  endtask

  task automatic attempt(int nbytes, bit success);
    step(.s(1));
    for (int i = 0; i < nbytes; i++) step(.r(1));
    if (success) step(.o(1)); else step(.c(1));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(0);
    chk("R11 status", reg_rdata, 0); chk("R11 go", tx_go, 0); chk("R11 dreq", tx_dreq, 1);
    chk("R11 irq", irq, 0); chk("R11 wr", wr_addr, 0);
    look(1); chk("R11 counter", reg_rdata, 0);

    write_frame(10, 1);
    look(1); chk("R10 counter", reg_rdata, 1); chk("R10 go", tx_go, 1);
    for (int i = 0; i < 3; i++) begin
      attempt(4, 0);
      look(0); chk("R3 rewind", rd_addr, 0); chk("R3 go", tx_go, 1);
    end
    chk("R1 count", reg_rdata, 3);
    attempt(10, 1);
    look(0); chk("R1 cleared", reg_rdata, 0); chk("R1 go idle", tx_go, 0);
    step(.rr(1));
    look(1); chk("R5 counter dec", reg_rdata, 0);

    write_frame(8, 1);
    write_frame(5, 1);
    for (int i = 0; i < 15; i++) attempt(2, 0);
    look(0); chk("R1 fifteen", reg_rdata, 15); chk("R3 go", tx_go, 1);
    attempt(2, 0);
    look(0);
    chk("R2 status", reg_rdata, 8'h90); chk("R2 irq", irq, 1);
    chk("R2 dreq", tx_dreq, 0); chk("R6 go", tx_go, 0);
    step(.s(1)); look(0); chk("R6 start ignored", tx_go, 0); chk("R6 rd", rd_addr, 10);
    step(.w(1)); look(0); chk("R6 write ignored", wr_addr, 23);
    int_mask = 1; look(0); chk("R4 masked", irq, 0);
    int_mask = 0; look(0); chk("R4 unmasked", irq, 1);
    step(.rr(1));
    look(0);
    chk("R7 skip", rd_addr, 18); chk("R7 wr kept", wr_addr, 23);
    chk("R5 cleared", reg_rdata, 0); chk("R5 irq", irq, 0); chk("R7 go", tx_go, 1);
    look(1); chk("R5 counter", reg_rdata, 1);
    attempt(5, 1);
    step(.rr(1));
    look(1); chk("R5 counter zero", reg_rdata, 0);

    cfg_wmark = 8'd40;
    write_frame(6, 0);
    look(0); chk("R9 go partial", tx_go, 1);
    for (int i = 0; i < 16; i++) attempt(1, 0);
    look(0); chk("R2 abort partial", reg_rdata, 8'h90);
    step(.rr(1));
    look(0); chk("R8 wr", wr_addr, 0); chk("R8 rd", rd_addr, 0); chk("R8 go", tx_go, 0);
    look(1); chk("R5 saturate", reg_rdata, 0);

    write_frame(90, 0);
    look(0); chk("R8 watermark reloaded", tx_dreq, 0);
    write_frame(38, 0);
    step(.w(1), .e(1));
    look(0); chk("R9 full ignored", wr_addr, 0); chk("R9 full dreq", tx_dreq, 0);
    step(.s(1));
    for (int i = 0; i < 30; i++) step(.r(1));
    look(0); chk("R9 protected", tx_dreq, 0);
    for (int i = 0; i < 34; i++) step(.r(1));
    look(0); chk("R9 released", tx_dreq, 1);
    for (int i = 0; i < 64; i++) step(.r(1));
    step(.o(1));
    look(0); chk("R1 done", reg_rdata, 0);
    repeat (4) look(0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule